// File: doc/BRIEF.md
# TDI Line-Scan Gate Clock Sequencer

This block produces the logic-level gate clocks for a full-frame CCD line sensor operated in time-delay-integration (TDI) mode. One line trigger starts one line period, which has two parts. First the vertical register is shifted by driving its two complementary phases. A transfer-gate pulse follows, and it overlaps the first horizontal phase. Then one line is read out through the horizontal register. Each output sample carries a reset-gate pulse and a summing-gate window. One clock after each reset pulse ends, a pixel-valid strobe tells the ADC to convert.

Readout has two modes. Full resolution gives one sample per horizontal pixel after one vertical shift. The 2x2 binned mode does two vertical shifts and sums two horizontal pixels on the summing gate per sample, so the number of samples per line is halved. All pulse widths are counts of the system clock taken from configuration inputs. Counts are latched when a line starts, and any count below its minimum is raised to that minimum. Every gate clock is fanned out identically to each sensor bank.

Top module: `tdi_clkseq`

## Requirements
- R1: After a synchronous reset, every vertical and horizontal phase-1 output is 0 and every phase-2 output is 1. Transfer, summing and reset gates are 0, and pixel-valid, line-done and overrun are 0. This holds until a trigger is accepted.
- R2: Effective counts are: vertical width TV = max(cfg_vwidth, MIN_V), overlap TO = max(cfg_overlap, MIN_OVR), horizontal half-period TH = max(cfg_hwidth, MIN_H) and reset width TR = min(max(cfg_rwidth, MIN_R), TH).
- R3: A trigger sampled at clock edge k while idle starts the line, and outputs change in the cycle after edge k+1. The block first makes NV vertical shifts (NV=1 full, NV=2 binned). Each shift is TV cycles with vphi1=1, vphi2=0, followed by TV cycles with vphi1=0, vphi2=1. Every bank bit carries the same value.
- R4: After the vertical shifts, tgate is 1 for TV+TO cycles while vphi2 stays 1. In the last TO of those cycles, hphi1=1 and hphi2=0.
- R5: After tgate falls, the block reads out NS samples (NS=PIXELS full, PIXELS/2 binned). Each sample is 2·HP half-periods of TH cycles (HP=1 full, 2 binned). The first half-period has hphi1=0 and hphi2=1, and the phases alternate after that. All banks are identical.
- R6: sgate is 1 for the first HP·TH cycles of each sample and 0 for the rest.
- R7: rgate is 1 for the first TR cycles of each sample.
- R8: pix_valid is 1 for exactly one cycle per sample, at sample offset TR+1, one cycle after rgate falls.
- R9: line_done is 1 for one cycle, right after the last sample, with all gates idle. A trigger presented during that cycle starts the next line.
- R10: A trigger sampled while a line is in progress, including the cycle before line_done shows, raises overrun in the next cycle and does not change the sequence.
- R11: Changes to the mode or count inputs during a line have no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_trig | input | 1 | Line start request |
| bin_mode | input | 1 | 1 selects 2x2 binned readout |
| cfg_vwidth | input | CNT_W | Vertical phase and transfer-gate width in clocks |
| cfg_overlap | input | CNT_W | Transfer-gate to horizontal phase-1 overlap in clocks |
| cfg_hwidth | input | CNT_W | Horizontal half-period in clocks |
| cfg_rwidth | input | CNT_W | Reset-gate pulse width in clocks |
| vphi1 | output | BANKS | Vertical phase 1, one bit per bank |
| vphi2 | output | BANKS | Vertical phase 2, one bit per bank |
| tgate | output | 1 | Transfer gate |
| hphi1 | output | BANKS | Horizontal phase 1, one bit per bank |
| hphi2 | output | BANKS | Horizontal phase 2, one bit per bank |
| sgate | output | 1 | Summing gate |
| rgate | output | 1 | Reset gate |
| pix_valid | output | 1 | One-cycle ADC convert strobe per sample |
| line_done | output | 1 | One-cycle end-of-line pulse |
| overrun | output | 1 | One-cycle pulse for a rejected trigger |

## Verification
When a trigger is accepted, the first active output appears two cycles after the clock edge that sampled the trigger. After that, every gate and strobe follows the offsets set by the latched counts, cycle by cycle. A rejected trigger shows overrun one cycle after its sampling edge. The bench turns each trigger into one expected output vector per clock cycle and queues them in order. It places the overrun flag in the queue slot of the following cycle. It compares all outputs in the middle of every cycle, so each result is checked in exactly the cycle in which it is due.

// File: rtl/tdi_clkseq_pkg.sv
// Shared types for the TDI gate clock sequencer.
// Assumes: one gate vector per cycle, bank fan-out done at the top.
package tdi_clkseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VSH,
        ST_TGH,
        ST_OVR,
        ST_RD,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic v1;
        logic v2;
        logic tg;
        logic h1;
        logic h2;
        logic sg;
        logic rg;
        logic pv;
        logic done;
        logic ovr;
    } gate_vec_t;

    localparam gate_vec_t GATE_IDLE = '{
        v1: 1'b0, v2: 1'b1, tg: 1'b0, h1: 1'b0, h2: 1'b1,
        sg: 1'b0, rg: 1'b0, pv: 1'b0, done: 1'b0, ovr: 1'b0
    };

endpackage

// File: rtl/tdi_cnt_clamp.sv
// Raises a programmed count to a floor and limits it to a ceiling.
// Assumes: FLOOR <= cap; pass all-ones as cap for no ceiling.
module tdi_cnt_clamp #(
    parameter int W     = 16,
    parameter int FLOOR = 1
) (
    input  logic [W-1:0] raw,
    input  logic [W-1:0] cap,
    output logic [W-1:0] eff
);
    localparam logic [W-1:0] FLOOR_W = W'(FLOOR);

    logic [W-1:0] lifted;

    // Apply the floor first, then the ceiling.
    always_comb begin
        lifted = (raw < FLOOR_W) ? FLOOR_W : raw;
        eff    = (lifted > cap) ? cap : lifted;
    end
endmodule

// File: rtl/tdi_line_fsm.sv
// Line sequencer: vertical shifts, transfer gate with overlap, then readout.
// Decodes one gate vector per cycle from its state; the caller registers it.
// Assumes: counts arrive already clamped, TH >= 2 and TR <= TH.
module tdi_line_fsm
    import tdi_clkseq_pkg::*;
#(
    parameter int PIXELS = 1536,
    parameter int W      = 16,
    parameter int MIN_V  = 3000,
    parameter int MIN_H  = 13
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      trig,
    input  logic      bin_mode,
    input  logic [W-1:0] tv,
    input  logic [W-1:0] tov,
    input  logic [W-1:0] th,
    input  logic [W-1:0] tr,
    output gate_vec_t dec
);
    localparam int SW = (PIXELS > 2) ? $clog2(PIXELS) : 1;
    localparam logic [SW-1:0] LAST_FULL = SW'(PIXELS - 1);
    localparam logic [SW-1:0] LAST_BIN  = SW'(PIXELS / 2 - 1);

    seq_state_t     state_q;
    logic           bin_q;
    logic [W-1:0]   tv_q, tov_q, th_q, tr_q;
    logic [W-1:0]   cnt_q;
    logic [1:0]     ph_q;
    logic [1:0]     half_q;
    logic [W+1:0]   soff_q;
    logic [SW-1:0]  samp_q;

    logic [1:0]     last_idx;
    logic [SW-1:0]  last_samp;

    // Index limits chosen by the latched readout mode.
    always_comb begin
        last_idx  = bin_q ? 2'd3 : 2'd1;
        last_samp = bin_q ? LAST_BIN : LAST_FULL;
    end

    // State, counters and latched configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bin_q   <= 1'b0;
            tv_q    <= '0;
            tov_q   <= '0;
            th_q    <= '0;
            tr_q    <= '0;
            cnt_q   <= '0;
            ph_q    <= '0;
            half_q  <= '0;
            soff_q  <= '0;
            samp_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (trig) begin
                        state_q <= ST_VSH;
                        bin_q   <= bin_mode;
                        tv_q    <= tv;
                        tov_q   <= tov;
                        th_q    <= th;
                        tr_q    <= tr;
                        cnt_q   <= '0;
                        ph_q    <= '0;
                    end
                end
                ST_VSH: begin
                    if (cnt_q == tv_q - 1'b1) begin
                        cnt_q <= '0;
                        if (ph_q == last_idx) state_q <= ST_TGH;
                        else                  ph_q    <= ph_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_TGH: begin
                    if (cnt_q == tv_q - 1'b1) begin
                        cnt_q   <= '0;
                        state_q <= ST_OVR;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_OVR: begin
                    if (cnt_q == tov_q - 1'b1) begin
                        cnt_q   <= '0;
                        half_q  <= '0;
                        soff_q  <= '0;
                        samp_q  <= '0;
                        state_q <= ST_RD;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_RD: begin
                    soff_q <= soff_q + 1'b1;
                    if (cnt_q == th_q - 1'b1) begin
                        cnt_q <= '0;
                        if (half_q == last_idx) begin
                            half_q <= '0;
                            soff_q <= '0;
                            if (samp_q == last_samp) state_q <= ST_DONE;
                            else                     samp_q  <= samp_q + 1'b1;
                        end else begin
                            half_q <= half_q + 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Gate levels implied by the current state and counters.
    always_comb begin
        dec     = GATE_IDLE;
        dec.ovr = trig && (state_q != ST_IDLE);
        case (state_q)
            ST_VSH: begin
                dec.v1 = ~ph_q[0];
                dec.v2 = ph_q[0];
            end
            ST_TGH: dec.tg = 1'b1;
            ST_OVR: begin
                dec.tg = 1'b1;
                dec.h1 = 1'b1;
                dec.h2 = 1'b0;
            end
            ST_RD: begin
                dec.h1 = half_q[0];
                dec.h2 = ~half_q[0];
                dec.sg = bin_q ? ~half_q[1] : (half_q == 2'd0);
                dec.rg = soff_q < {2'b00, tr_q};
                dec.pv = soff_q == ({2'b00, tr_q} + 1'b1);
            end
            ST_DONE: dec.done = 1'b1;
            default: ;
        endcase
    end

    // Latched counts respect their floors while a line runs.
    assert_count_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (tv_q >= W'(MIN_V)) && (th_q >= W'(MIN_H)));

    // Reset pulse never outlasts a horizontal half-period.
    assert_rg_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (tr_q <= th_q));

    // A line begins only from idle; busy triggers never restart it.
    assert_start_from_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_VSH) |-> ($past(state_q) == ST_IDLE));
endmodule

// File: rtl/tdi_gate_reg.sv
// Output register for the gate vector, so that no gate clock glitches.
// Assumes: a synchronous reset that parks every gate at its idle level.
module tdi_gate_reg
    import tdi_clkseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  gate_vec_t d,
    output gate_vec_t q
);
    // Register all gates together so they share one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= GATE_IDLE;
        else        q <= d;
    end

    // ADC strobe comes one cycle after a reset pulse ends.
    assert_pv_after_rg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.pv |-> ($past(q.rg, 2) && !$past(q.rg)));

    // Transfer gate falls only while horizontal phase 1 is high.
    assert_tg_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.tg) |-> $past(q.h1));

    // Summing only happens during readout, never with the transfer gate.
    assert_sg_no_tg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.sg |-> !q.tg);

    // End-of-line is a single-cycle pulse.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
endmodule

// File: rtl/tdi_clkseq.sv
// Top of the TDI gate clock sequencer: clamps counts, runs the line FSM,
// registers the gates and fans each clock out to every sensor bank.
// Assumes: PIXELS even, MIN_H >= 2, MIN_R <= MIN_H.
module tdi_clkseq
    import tdi_clkseq_pkg::*;
#(
    parameter int PIXELS  = 1536,
    parameter int BANKS   = 2,
    parameter int CNT_W   = 16,
    parameter int MIN_V   = 3000,
    parameter int MIN_OVR = 1000,
    parameter int MIN_H   = 13,
    parameter int MIN_R   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_trig,
    input  logic             bin_mode,
    input  logic [CNT_W-1:0] cfg_vwidth,
    input  logic [CNT_W-1:0] cfg_overlap,
    input  logic [CNT_W-1:0] cfg_hwidth,
    input  logic [CNT_W-1:0] cfg_rwidth,
    output logic [BANKS-1:0] vphi1,
    output logic [BANKS-1:0] vphi2,
    output logic             tgate,
    output logic [BANKS-1:0] hphi1,
    output logic [BANKS-1:0] hphi2,
    output logic             sgate,
    output logic             rgate,
    output logic             pix_valid,
    output logic             line_done,
    output logic             overrun
);
    localparam logic [CNT_W-1:0] NO_CAP = '1;

    logic [CNT_W-1:0] tv_eff, tov_eff, th_eff, tr_eff;
    gate_vec_t        dec, gq;

    tdi_cnt_clamp #(.W(CNT_W), .FLOOR(MIN_V)) u_clamp_v (
        .raw(cfg_vwidth), .cap(NO_CAP), .eff(tv_eff));
    tdi_cnt_clamp #(.W(CNT_W), .FLOOR(MIN_OVR)) u_clamp_o (
        .raw(cfg_overlap), .cap(NO_CAP), .eff(tov_eff));
    tdi_cnt_clamp #(.W(CNT_W), .FLOOR(MIN_H)) u_clamp_h (
        .raw(cfg_hwidth), .cap(NO_CAP), .eff(th_eff));
    tdi_cnt_clamp #(.W(CNT_W), .FLOOR(MIN_R)) u_clamp_r (
        .raw(cfg_rwidth), .cap(th_eff), .eff(tr_eff));

    tdi_line_fsm #(
        .PIXELS(PIXELS), .W(CNT_W), .MIN_V(MIN_V), .MIN_H(MIN_H)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .trig(line_trig), .bin_mode(bin_mode),
        .tv(tv_eff), .tov(tov_eff), .th(th_eff), .tr(tr_eff), .dec(dec));

    tdi_gate_reg u_oreg (.clk(clk), .rst_n(rst_n), .d(dec), .q(gq));

    // Identical phase clocks for every bank.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign vphi1[b] = gq.v1;
        assign vphi2[b] = gq.v2;
        assign hphi1[b] = gq.h1;
        assign hphi2[b] = gq.h2;
    end

    assign tgate     = gq.tg;
    assign sgate     = gq.sg;
    assign rgate     = gq.rg;
    assign pix_valid = gq.pv;
    assign line_done = gq.done;
    assign overrun   = gq.ovr;
endmodule

// File: tb/tdi_clkseq_bench.sv
// Scoreboard bench: each trigger queues one expected vector per cycle,
// and a mid-cycle monitor pops and compares them.
module tdi_clkseq_bench;
    localparam int PIXELS  = 6;
    localparam int BANKS   = 2;
    localparam int CNT_W   = 8;
    localparam int MIN_V   = 3;
    localparam int MIN_OVR = 2;
    localparam int MIN_H   = 2;
    localparam int MIN_R   = 1;

    typedef struct packed {
        logic v1, v2, tg, h1, h2, sg, rg, pv, done, ovr;
    } exp_t;

    localparam exp_t IDLE_V = '{v1: 1'b0, v2: 1'b1, tg: 1'b0, h1: 1'b0, h2: 1'b1,
                                sg: 1'b0, rg: 1'b0, pv: 1'b0, done: 1'b0, ovr: 1'b0};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             line_trig = 1'b0;
    logic             bin_mode = 1'b0;
    logic [CNT_W-1:0] cfg_vwidth = '0, cfg_overlap = '0, cfg_hwidth = '0, cfg_rwidth = '0;
    logic [BANKS-1:0] vphi1, vphi2, hphi1, hphi2;
    logic             tgate, sgate, rgate, pix_valid, line_done, overrun;

    exp_t  exp_q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    mon_on = 1'b0;
    bit    finished = 1'b0;
    string scen = "reset";

    tdi_clkseq #(
        .PIXELS(PIXELS), .BANKS(BANKS), .CNT_W(CNT_W), .MIN_V(MIN_V),
        .MIN_OVR(MIN_OVR), .MIN_H(MIN_H), .MIN_R(MIN_R)
    ) u_tdi_clkseq (
        .clk(clk), .rst_n(rst_n), .line_trig(line_trig), .bin_mode(bin_mode),
        .cfg_vwidth(cfg_vwidth), .cfg_overlap(cfg_overlap),
        .cfg_hwidth(cfg_hwidth), .cfg_rwidth(cfg_rwidth),
        .vphi1(vphi1), .vphi2(vphi2), .tgate(tgate), .hphi1(hphi1), .hphi2(hphi2),
        .sgate(sgate), .rgate(rgate), .pix_valid(pix_valid),
        .line_done(line_done), .overrun(overrun));

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s (%s) t=%0t actual=%h expected=%h", tag, scen, $time, act, expv);
        end
    endtask

    task automatic chk_all(input exp_t e);
        chk("R3 vertical", {2'b00, vphi1[0], vphi2[0]} | {vphi1 != {BANKS{vphi1[0]}}, 3'b0},
            {2'b00, e.v1, e.v2});
        chk("R3 banks", {3'b0, vphi2 != {BANKS{vphi2[0]}}}, 4'h0);
        chk("R4 tgate", {3'b0, tgate}, {3'b0, e.tg});
        chk("R5 horizontal", {2'b00, hphi1[0], hphi2[0]}, {2'b00, e.h1, e.h2});
        chk("R5 banks", {2'b00, hphi1 != {BANKS{hphi1[0]}}, hphi2 != {BANKS{hphi2[0]}}}, 4'h0);
        chk("R6 sgate", {3'b0, sgate}, {3'b0, e.sg});
        chk("R7 rgate", {3'b0, rgate}, {3'b0, e.rg});
        chk("R8 pix_valid", {3'b0, pix_valid}, {3'b0, e.pv});
        chk("R9 line_done", {3'b0, line_done}, {3'b0, e.done});
        chk("R10 overrun", {3'b0, overrun}, {3'b0, e.ovr});
    endtask

    // Monitor: one expected vector per cycle, compared mid-cycle.
    always @(negedge clk) begin
        exp_t e;
        if (mon_on && !finished) begin
            e = (exp_q.size() > 0) ? exp_q.pop_front() : IDLE_V;
            chk_all(e);
        end
    end

    // Driver: presents a trigger for one cycle and queues what it must cause.
    task automatic fire(input bit bin, input int cv, input int co, input int ch, input int cr);
        int tv, tov, th, tr, nv, hp, ns, len;
        exp_t v;
        bin_mode    = bin;
        cfg_vwidth  = CNT_W'(cv);
        cfg_overlap = CNT_W'(co);
        cfg_hwidth  = CNT_W'(ch);
        cfg_rwidth  = CNT_W'(cr);
        line_trig   = 1'b1;
        if (exp_q.size() >= 2) begin
            exp_q[1].ovr = 1'b1; // R10: busy trigger, flag in the next cycle only
        end else begin
            // R2: effective counts
            tv  = (cv < MIN_V) ? MIN_V : cv;
            tov = (co < MIN_OVR) ? MIN_OVR : co;
            th  = (ch < MIN_H) ? MIN_H : ch;
            tr  = (cr < MIN_R) ? MIN_R : cr;
            if (tr > th) tr = th;
            nv  = bin ? 2 : 1;
            hp  = bin ? 2 : 1;
            ns  = bin ? PIXELS / 2 : PIXELS;
            len = 2 * hp * th;
            while (exp_q.size() < 2) exp_q.push_back(IDLE_V);
            for (int s = 0; s < nv; s++) begin          // R3
                v = IDLE_V; v.v1 = 1'b1; v.v2 = 1'b0;
                for (int i = 0; i < tv; i++) exp_q.push_back(v);
                v = IDLE_V;
                for (int i = 0; i < tv; i++) exp_q.push_back(v);
            end
            v = IDLE_V; v.tg = 1'b1;                    // R4
            for (int i = 0; i < tv; i++) exp_q.push_back(v);
            v.h1 = 1'b1; v.h2 = 1'b0;
            for (int i = 0; i < tov; i++) exp_q.push_back(v);
            for (int j = 0; j < ns; j++) begin          // R5..R8
                for (int o = 0; o < len; o++) begin
                    v = IDLE_V;
                    v.h1 = ((o / th) % 2) == 1;
                    v.h2 = !v.h1;
                    v.sg = o < hp * th;
                    v.rg = o < tr;
                    v.pv = o == tr + 1;
                    exp_q.push_back(v);
                end
            end
            v = IDLE_V; v.done = 1'b1;                  // R9
            exp_q.push_back(v);
        end
        @(posedge clk); #1;
        line_trig = 1'b0;
    endtask

    task automatic wait_size(input int n);
        while (exp_q.size() != n) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) begin
            @(posedge clk); #1;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        scen = "R1 in reset";
        @(negedge clk);
        chk_all(IDLE_V); // R1
        @(posedge clk); #1;
        rst_n = 1'b1;
        mon_on = 1'b1;
        scen = "R1 idle after reset";
        idle_cycles(6);

        scen = "R3 full mode nominal";
        fire(1'b0, 4, 3, 3, 2);
        wait_size(0); idle_cycles(2);

        scen = "R5 binned mode";
        fire(1'b1, 3, 2, 2, 2);
        wait_size(0); idle_cycles(2);

        scen = "R2 clamp below floor, reset width capped";
        fire(1'b0, 0, 1, 0, 7);
        wait_size(0); idle_cycles(2);

        scen = "R2 zero reset width binned";
        fire(1'b1, 1, 0, 3, 0);
        wait_size(0); idle_cycles(2);

        scen = "R10 trigger on first busy cycle";
        fire(1'b0, 3, 2, 3, 1);
        fire(1'b1, 9, 9, 9, 9);
        idle_cycles(20);
        scen = "R11 config change mid line";
        bin_mode = 1'b1; cfg_hwidth = 8'd9; cfg_rwidth = 8'd5;
        fire(1'b1, 7, 7, 7, 7);
        scen = "R10 trigger one cycle before line end";
        wait_size(2);
        fire(1'b0, 5, 5, 5, 5);
        scen = "R9 trigger during line_done cycle";
        wait_size(1);
        fire(1'b1, 4, 3, 2, 1);
        wait_size(0); idle_cycles(3);

        scen = "R8 wide half-period full mode";
        fire(1'b0, 3, 2, 5, 5);
        wait_size(0); idle_cycles(4);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: an expired run counts as a failure.
    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog (%s) actual=hung expected=finished", scen);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule